// File: doc/BRIEF.md
# Panel Power Sequencer

This block brings a display panel up and down in a fixed order from one level-sensitive request. Raising the request first turns on the display controller. It then waits a settle interval so the panel's contrast supply can stabilise, and only then switches panel power on. Dropping the request runs the same steps in reverse. Panel power goes off first, the same settle interval passes, and then the controller enable is cleared. An optional board-specific step can be placed in each gap. It is a handshake: the block raises an activity flag and waits until the board logic reports that the step is done.

The vertical-blank interrupt enable is only granted while the panel is fully on. It opens when power-up has finished and closes at the start of power-down. All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready interface and no back-pressure. A request level that changes while a sequence is running is not lost. The running sequence finishes, and then the sequencer follows the request level it sees.

Top module: `panel_power_seq`

## Requirements
- R1: During and right after reset, ctrl_en, panel_pwr, vblank_irq_en, busy, ready, hook_on_act and hook_off_act are all 0.
- R2: When the panel is off and idle and power_req is sampled 1, ctrl_en is 1 from the next cycle. panel_pwr rises only after ctrl_en has been 1 for SETTLE_CYCLES plus the hook cycles. Without a hook wait this is exactly SETTLE_CYCLES+1 cycles in which ctrl_en=1 and panel_pwr=0.
- R3: When the panel is fully on and power_req is sampled 0, panel_pwr and vblank_irq_en are 0 from the next cycle. ctrl_en falls after SETTLE_CYCLES plus the hook cycles, during which ctrl_en=1 and panel_pwr=0.
- R4: vblank_irq_en is 1 exactly while the sequencer is fully on (ready=1, panel_pwr=1, ctrl_en=1). It is 0 at all other times.
- R5: busy is 1 in every cycle of a power-up or power-down sequence. ready is 1 only when fully on and idle. busy and ready are never 1 together.
- R6: A change of power_req during a sequence is held until that sequence completes. The opposite sequence then starts on the next cycle, so the idle state in between lasts exactly one cycle.
- R7: With HAS_HOOK=1, hook_on_act is 1 after the power-up settle interval and until hook_done is sampled 1. panel_pwr rises in the cycle after that sample.
- R8: With HAS_HOOK=1, hook_off_act is 1 after the power-down settle interval and until hook_done is sampled 1. ctrl_en falls in the cycle after that sample.
- R9: With HAS_HOOK=0, hook_on_act and hook_off_act stay 0 and hook_done has no effect. Each hook slot then takes exactly one cycle.
- R10: panel_pwr is never 1 while ctrl_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the settle interval is counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| power_req | input | 1 | Requested state level: 1 means panel on, 0 means panel off |
| hook_done | input | 1 | Board-specific step has completed |
| ctrl_en | output | 1 | Display controller enable |
| panel_pwr | output | 1 | Panel power switch |
| vblank_irq_en | output | 1 | Permission for the vertical-blank interrupt |
| busy | output | 1 | A power-up or power-down sequence is in progress |
| ready | output | 1 | Panel fully on and sequencer idle |
| hook_on_act | output | 1 | Board-specific power-up step is running |
| hook_off_act | output | 1 | Board-specific power-down step is running |

## Verification
The bench builds two instances, both with SETTLE_CYCLES=8. One has HAS_HOOK=1 and the other has HAS_HOOK=0. The short settle interval lets many full on/off cycles run, and the exact gap in each direction can be counted and compared with SETTLE_CYCLES+1+hook delay. The hooked instance varies how long hook_done stays away, which exercises both gap extensions. The hook-free instance shows that hook_done is ignored, and it also covers requests that flip in the middle of a sequence.

// File: rtl/psq_pkg.sv
package psq_pkg;
  typedef enum logic [2:0] {
    PS_OFF      = 3'd0,
    PS_EN_WAIT  = 3'd1,
    PS_HOOK_ON  = 3'd2,
    PS_ON       = 3'd3,
    PS_DN_WAIT  = 3'd4,
    PS_HOOK_OFF = 3'd5
  } psq_state_e;
endpackage

// File: rtl/psq_settle_timer.sv
// Counts the settle interval while run is high; expire marks its last cycle.
module psq_settle_timer #(
  parameter int unsigned CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int unsigned W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [W-1:0] LAST = W'(CYCLES - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == LAST);
endmodule

// File: rtl/psq_hook_gate.sv
// Selects between a handshaked board step and a single pass-through cycle.
module psq_hook_gate
  import psq_pkg::*;
#(
  parameter bit HAS_HOOK = 1'b1
) (
  input  psq_state_e state,
  input  logic       hook_done,
  output logic       hook_on_act,
  output logic       hook_off_act,
  output logic       hook_adv
);
  generate
    if (HAS_HOOK) begin : g_hook
      assign hook_on_act  = (state == PS_HOOK_ON);
      assign hook_off_act = (state == PS_HOOK_OFF);
      assign hook_adv     = hook_done;
    end else begin : g_nohook
      logic unused_hook_done;
      assign unused_hook_done = hook_done;
      assign hook_on_act  = 1'b0;
      assign hook_off_act = 1'b0;
      assign hook_adv     = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/psq_fsm.sv
// Sequencing state machine; only OFF and ON react to the request level.
module psq_fsm
  import psq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       power_req,
  input  logic       settle_done,
  input  logic       hook_adv,
  output psq_state_e state,
  output logic       timer_run
);
  psq_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      PS_OFF:      if (power_req)   nxt = PS_EN_WAIT;
      PS_EN_WAIT:  if (settle_done) nxt = PS_HOOK_ON;
      PS_HOOK_ON:  if (hook_adv)    nxt = PS_ON;
      PS_ON:       if (!power_req)  nxt = PS_DN_WAIT;
      PS_DN_WAIT:  if (settle_done) nxt = PS_HOOK_OFF;
      PS_HOOK_OFF: if (hook_adv)    nxt = PS_OFF;
      default:                      nxt = PS_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= PS_OFF;
    else        state <= nxt;
  end

  assign timer_run = (state == PS_EN_WAIT) || (state == PS_DN_WAIT);
endmodule

// File: rtl/panel_power_seq.sv
module panel_power_seq
  import psq_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 1000000,
  parameter bit          HAS_HOOK      = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic power_req,
  input  logic hook_done,
  output logic ctrl_en,
  output logic panel_pwr,
  output logic vblank_irq_en,
  output logic busy,
  output logic ready,
  output logic hook_on_act,
  output logic hook_off_act
);
  psq_state_e state;
  logic timer_run, settle_done, hook_adv;

  psq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .power_req  (power_req),
    .settle_done(settle_done),
    .hook_adv   (hook_adv),
    .state      (state),
    .timer_run  (timer_run)
  );

  psq_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (timer_run),
    .expire(settle_done)
  );

  psq_hook_gate #(.HAS_HOOK(HAS_HOOK)) u_hook (
    .state       (state),
    .hook_done   (hook_done),
    .hook_on_act (hook_on_act),
    .hook_off_act(hook_off_act),
    .hook_adv    (hook_adv)
  );

  always_comb begin
    ctrl_en       = 1'b0;
    panel_pwr     = 1'b0;
    vblank_irq_en = 1'b0;
    busy          = 1'b0;
    ready         = 1'b0;
    unique case (state)
      PS_OFF: ;
      PS_EN_WAIT, PS_HOOK_ON, PS_DN_WAIT, PS_HOOK_OFF: begin
        ctrl_en = 1'b1;
        busy    = 1'b1;
      end
      PS_ON: begin
        ctrl_en       = 1'b1;
        panel_pwr     = 1'b1;
        vblank_irq_en = 1'b1;
        ready         = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/panel_power_seq_chk.sv
module panel_power_seq_chk #(
  parameter int unsigned SETTLE_CYCLES = 1000000
) (
  input logic clk,
  input logic rst_n,
  input logic power_req,
  input logic ctrl_en,
  input logic panel_pwr,
  input logic vblank_irq_en,
  input logic busy,
  input logic ready,
  input logic hook_on_act,
  input logic hook_off_act
);
  localparam int unsigned AW = $clog2(SETTLE_CYCLES + 2);
  localparam logic [AW-1:0] CAP = AW'(SETTLE_CYCLES + 1);
  localparam logic [AW-1:0] MIN = AW'(SETTLE_CYCLES);

  logic [AW-1:0] en_age, off_age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_age  <= '0;
      off_age <= '0;
    end else begin
      if (!ctrl_en)           en_age <= '0;
      else if (en_age != CAP) en_age <= en_age + 1'b1;
      if (panel_pwr)           off_age <= '0;
      else if (off_age != CAP) off_age <= off_age + 1'b1;
    end
  end

  p_pwr_under_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    panel_pwr |-> ctrl_en);
  p_up_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(panel_pwr) |-> (en_age >= MIN));
  p_down_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_en) |-> (off_age >= MIN));
  p_vblank_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq_en |-> (ready && panel_pwr));
  p_busy_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && ready));
  p_start_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !busy && power_req) |=> ctrl_en);
  p_start_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !power_req) |=> (!panel_pwr && !vblank_irq_en));
  p_hook_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hook_on_act |-> (ctrl_en && !panel_pwr && busy));
  p_hook_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hook_off_act |-> (ctrl_en && !panel_pwr && !vblank_irq_en));
endmodule

bind panel_power_seq panel_power_seq_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .power_req    (power_req),
  .ctrl_en      (ctrl_en),
  .panel_pwr    (panel_pwr),
  .vblank_irq_en(vblank_irq_en),
  .busy         (busy),
  .ready        (ready),
  .hook_on_act  (hook_on_act),
  .hook_off_act (hook_off_act)
);

// File: tb/panel_power_seq_bench.sv
module panel_power_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int S = 8;
  // vector: {hook delay in cycles, expected gap = S+1+delay}
  localparam int unsigned VEC [4][2] = '{'{0, 9}, '{1, 10}, '{3, 12}, '{6, 15}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_h = 1'b0, hd_h = 1'b0, req_n = 1'b0, hd_n = 1'b0;
  logic en_h, pwr_h, vb_h, busy_h, rdy_h, hon_h, hoff_h;
  logic en_n, pwr_n, vb_n, busy_n, rdy_n, hon_n, hoff_n;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  panel_power_seq #(.SETTLE_CYCLES(S), .HAS_HOOK(1'b1)) u_panel_power_seq (
    .clk(clk), .rst_n(rst_n), .power_req(req_h), .hook_done(hd_h),
    .ctrl_en(en_h), .panel_pwr(pwr_h), .vblank_irq_en(vb_h), .busy(busy_h),
    .ready(rdy_h), .hook_on_act(hon_h), .hook_off_act(hoff_h));

  panel_power_seq #(.SETTLE_CYCLES(S), .HAS_HOOK(1'b0)) u_panel_power_seq_nh (
    .clk(clk), .rst_n(rst_n), .power_req(req_n), .hook_done(hd_n),
    .ctrl_en(en_n), .panel_pwr(pwr_n), .vblank_irq_en(vb_n), .busy(busy_n),
    .ready(rdy_n), .hook_on_act(hon_n), .hook_off_act(hoff_n));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic g_en(bit n);   return n ? en_n : en_h;     endfunction
  function automatic logic g_pwr(bit n);  return n ? pwr_n : pwr_h;   endfunction
  function automatic logic g_vb(bit n);   return n ? vb_n : vb_h;     endfunction
  function automatic logic g_busy(bit n); return n ? busy_n : busy_h; endfunction
  function automatic logic g_rdy(bit n);  return n ? rdy_n : rdy_h;   endfunction
  function automatic logic g_hook(bit n, bit up);
    if (n) return up ? hon_n : hoff_n;
    return up ? hon_h : hoff_h;
  endfunction

  task automatic set_req(bit n, logic v);
    if (n) req_n = v; else req_h = v;
  endtask

  // Runs one sequence; counts cycles with ctrl_en=1 and panel_pwr=0.
  task automatic run_seq(input bit n, input bit up, input int d,
                         output int gap, output bit busy_ok, output int hook_seen,
                         output logic first_en, output logic first_pwr);
    int hs = 0;
    gap = 0; busy_ok = 1'b1; hook_seen = 0;
    set_req(n, up);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (i == 0) begin first_en = g_en(n); first_pwr = g_pwr(n); end
      if (g_en(n) && !g_pwr(n)) begin
        gap++;
        if (!g_busy(n)) busy_ok = 1'b0;
      end
      if (g_hook(n, up)) begin
        hook_seen++;
        if (!n && hs == d) hd_h = 1'b1;
        hs++;
      end else if (!n) hd_h = 1'b0;
      if (up && g_pwr(n)) break;
      if (!up && !g_en(n)) break;
    end
    if (!n) hd_h = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int gap, hs, cnt;
    bit bok;
    logic fe, fp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!en_h && !pwr_h && !vb_h && !busy_h && !rdy_h && !hon_h && !hoff_h,
        "R1 reset outputs hooked", {en_h, pwr_h, vb_h, busy_h, rdy_h}, 0);
    chk(!en_n && !pwr_n && !vb_n && !busy_n && !rdy_n, "R1 reset outputs plain",
        {en_n, pwr_n, vb_n, busy_n, rdy_n}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!en_h && !busy_h && !rdy_h, "R1 idle after reset", {en_h, busy_h, rdy_h}, 0);

    // Table walk on the hooked instance: R2 R3 R4 R5 R7 R8
    for (int v = 0; v < 4; v++) begin
      run_seq(1'b0, 1'b1, int'(VEC[v][0]), gap, bok, hs, fe, fp);
      chk(fe === 1'b1, "R2 ctrl_en next cycle", fe, 1);
      chk(gap == int'(VEC[v][1]), "R7 up gap with hook wait", gap, int'(VEC[v][1]));
      chk(bok, "R5 busy during power-up", bok, 1);
      chk(hs == int'(VEC[v][0]) + 1, "R7 hook_on_act length", hs, int'(VEC[v][0]) + 1);
      @(negedge clk);
      chk(vb_h && rdy_h && !busy_h && pwr_h, "R4 vblank when fully on",
          {vb_h, rdy_h, busy_h, pwr_h}, 4'b1101);
      run_seq(1'b0, 1'b0, int'(VEC[v][0]), gap, bok, hs, fe, fp);
      chk(fp === 1'b0 && !vb_h, "R3 panel power off first", fp, 0);
      chk(gap == int'(VEC[v][1]), "R8 down gap with hook wait", gap, int'(VEC[v][1]));
      chk(bok, "R5 busy during power-down", bok, 1);
      @(negedge clk);
      chk(!en_h && !pwr_h && !vb_h && !busy_h, "R3 all low after down",
          {en_h, pwr_h, vb_h, busy_h}, 0);
    end

    // R9: hook-free instance ignores hook_done (held high throughout)
    hd_n = 1'b1;
    run_seq(1'b1, 1'b1, 0, gap, bok, hs, fe, fp);
    chk(gap == S + 1, "R9 up gap no hook", gap, S + 1);
    chk(hs == 0, "R9 hook_on_act stays low", hs, 0);
    chk(!vb_n || rdy_n, "R4 vblank only with ready", vb_n, rdy_n);
    run_seq(1'b1, 1'b0, 0, gap, bok, hs, fe, fp);
    chk(gap == S + 1, "R9 down gap no hook", gap, S + 1);
    chk(hs == 0, "R9 hook_off_act stays low", hs, 0);
    hd_n = 1'b0;
    @(negedge clk);

    // R6: request dropped during power-up is held
    req_n = 1'b1;
    @(negedge clk);
    req_n = 1'b0;
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pwr_n) cnt++;
      if (!en_n) break;
    end
    chk(cnt == 1, "R6 held down request after up", cnt, 1);
    chk(!en_n && !busy_n, "R6 back to off", en_n, 0);

    // R6: request raised during power-down is held
    run_seq(1'b1, 1'b1, 0, gap, bok, hs, fe, fp);
    req_n = 1'b0;
    @(negedge clk);
    chk(!pwr_n && en_n, "R10 power down started", pwr_n, 0);
    req_n = 1'b1;
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!en_n) cnt++;
      if (cnt > 0 && en_n) break;
    end
    chk(cnt == 1, "R6 one idle cycle before up again", cnt, 1);
    chk(en_n && !pwr_n && busy_n, "R10 enable before power", pwr_n, 0);
    run_seq(1'b1, 1'b0, 0, gap, bok, hs, fe, fp);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule